// File: doc/BRIEF.md
# Configurable Pixel Component Extractor

This block turns raw framebuffer pixel words into one 24-bit RGB value. Each of the three colour channels has its own select register. The register gives a bit offset into the pixel word, a number of bits to take from there, and an 8-bit fallback value. A format register sets how many bytes of the incoming word belong to the pixel. Bytes above that count read as zero.

The taken field is left-aligned into the 8-bit channel, and its lower bits are filled with zeros. A channel shows its fallback value in three cases: its length field is zero, the pixel lies outside the visible area, or the pixel stream has underrun. For example, a red fallback of 0xFF makes underruns show up as red pixels.

Settings are loaded through a plain write port. The result appears one clock after the pixel is presented.

Top module: `pcx_extract`

## Requirements
- R1: After reset, the format register and all three select registers are zero, `rgb_valid` is 0 and `rgb_out` is zero.
- R2: `rgb_valid` equals `pix_valid` of the previous cycle, and `rgb_out` holds its value in every cycle that follows a cycle without `pix_valid`.
- R3: The format register (address 0) holds the bytes-per-pixel count minus one in bits [4:3]. Pixel bytes are little-endian, with byte 0 in `pix_data[7:0]`. Bytes at or above the count read as zero.
- R4: The select registers sit at address 1 (red), 2 (green) and 3 (blue). In each one, bits [23:16] are the fallback value, bits [11:8] the length and bits [4:0] the offset of the lowest bit taken.
- R5: A taken field of length L is placed in channel bits [7:8-L], and channel bits [7-L:0] are zero.
- R6: A length of zero makes the channel equal its fallback value.
- R7: A length field above 8 is treated as 8.
- R8: Bit positions beyond bit 31 of the pixel word read as zero.
- R9: When `pix_visible` is 0, every channel equals its fallback value.
- R10: When `pix_underrun` is 1, every channel equals its fallback value.
- R11: A register write applies to pixels presented in later cycles. A pixel presented in the same cycle as a write uses the old settings.
- R12: `rgb_out` packs red in [23:16], green in [15:8] and blue in [7:0], and each channel uses only its own select register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address (0 format, 1 red, 2 green, 3 blue) |
| cfg_wdata | input | 32 | Register write data |
| pix_valid | input | 1 | Pixel word present |
| pix_data | input | 32 | Pixel word, little-endian bytes |
| pix_visible | input | 1 | Pixel lies in the visible area |
| pix_underrun | input | 1 | Pixel stream has underrun |
| rgb_valid | output | 1 | Output pixel valid |
| rgb_out | output | 24 | Red, green and blue channels |

## Verification
A pixel driven before a rising edge has its RGB value and `rgb_valid` at that edge. The bench drives inputs on the falling edge and checks the outputs on the next falling edge. A register write, whose effect starts one edge after the strobe, is checked by a pixel presented in the following cycle. A pixel sent in the same cycle as a write is expected to use the old settings. Idle cycles are checked on the falling edge after a pixel result, to confirm the output holds and `rgb_valid` drops.

// File: rtl/pcx_pkg.sv
package pcx_pkg;

    localparam int REG_W    = 32;
    localparam int COMP_W   = 8;
    localparam int LEN_W    = 4;
    localparam int OFF_W    = 5;
    localparam int NUM_COMP = 3;
    localparam int ADDR_W   = 2;
    localparam int FMT_LSB  = 3;

    typedef struct packed {
        logic [COMP_W-1:0] dflt;
        logic [LEN_W-1:0]  len;
        logic [OFF_W-1:0]  off;
    } sel_t;

    typedef enum logic [ADDR_W-1:0] {
        A_FMT = 2'd0,
        A_RED = 2'd1,
        A_GRN = 2'd2,
        A_BLU = 2'd3
    } reg_addr_e;

    function automatic sel_t decode_sel(input logic [REG_W-1:0] w);
        sel_t s;
        s.dflt = w[23:16];
        s.len  = w[11:8];
        s.off  = w[4:0];
        return s;
    endfunction

    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] l);
        return (l > LEN_W'(COMP_W)) ? LEN_W'(COMP_W) : l;
    endfunction

endpackage

// File: rtl/pcx_regs.sv
module pcx_regs
    import pcx_pkg::*;
#(
    parameter int BPP_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic [BPP_W-1:0]  bpp_m1,
    output sel_t              sel [NUM_COMP]
);

    reg_addr_e addr_e;
    assign addr_e = reg_addr_e'(wr_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            bpp_m1 <= '0;
        end else if (wr_en && addr_e == A_FMT) begin
            bpp_m1 <= wr_data[FMT_LSB +: BPP_W];
        end
    end

    for (genvar c = 0; c < NUM_COMP; c++) begin : g_sel
        always_ff @(posedge clk) begin
            if (rst) begin
                sel[c] <= '0;
            end else if (wr_en && wr_addr == ADDR_W'(c + 1)) begin
                sel[c] <= decode_sel(wr_data);
            end
        end
    end

    // R4: a red write lands in the red register fields
    assert_red_write_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && $past(wr_addr) == 2'd1 && !$past(rst)) |->
        (sel[0].dflt == $past(wr_data[23:16]) && sel[0].len == $past(wr_data[11:8])
         && sel[0].off == $past(wr_data[4:0])));

    // R1: reset clears the format register
    assert_fmt_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> bpp_m1 == '0);

endmodule

// File: rtl/pcx_byte_gate.sv
module pcx_byte_gate #(
    parameter int PIX_BYTES = 4,
    parameter int BPP_W     = 2
) (
    input  logic [PIX_BYTES*8-1:0] word_i,
    input  logic [BPP_W-1:0]       bpp_m1,
    output logic [PIX_BYTES*8-1:0] word_o
);

    for (genvar b = 0; b < PIX_BYTES; b++) begin : g_byte
        logic keep;
        assign keep = (b <= int'(bpp_m1));
        assign word_o[b*8 +: 8] = keep ? word_i[b*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/pcx_lane.sv
module pcx_lane
    import pcx_pkg::*;
#(
    parameter int PIX_W = 32
) (
    input  logic [PIX_W-1:0]  word,
    input  sel_t              sel,
    input  logic              force_dflt,
    output logic [COMP_W-1:0] comp
);

    logic [PIX_W-1:0]  shifted;
    logic [LEN_W-1:0]  len_eff;
    logic [LEN_W:0]    shamt;
    logic [COMP_W-1:0] field;
    logic [COMP_W-1:0] aligned;
    logic [COMP_W-1:0] low_mask;
    logic              use_dflt;

    assign shifted  = word >> sel.off;
    assign len_eff  = clamp_len(sel.len);
    assign shamt    = (LEN_W+1)'(COMP_W) - {1'b0, len_eff};
    assign use_dflt = force_dflt || (len_eff == '0);

    always_comb begin
        for (int i = 0; i < COMP_W; i++) begin
            field[i]    = shifted[i] & (i < int'(len_eff));
            low_mask[i] = (i < int'(shamt));
        end
        aligned = field << shamt;
        comp    = use_dflt ? sel.dflt : aligned;
    end

    // R5: bits below the aligned field are zero
    always_comb begin
        assert_zero_fill_R5: assert (use_dflt || ((comp & low_mask) == '0));
    end

endmodule

// File: rtl/pcx_extract.sv
module pcx_extract
    import pcx_pkg::*;
#(
    parameter int PIX_BYTES = 4,
    localparam int PIX_W    = PIX_BYTES * 8,
    localparam int BPP_W    = (PIX_BYTES > 1) ? $clog2(PIX_BYTES) : 1,
    localparam int RGB_W    = NUM_COMP * COMP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              pix_valid,
    input  logic [PIX_W-1:0]  pix_data,
    input  logic              pix_visible,
    input  logic              pix_underrun,
    output logic              rgb_valid,
    output logic [RGB_W-1:0]  rgb_out
);

    logic [BPP_W-1:0]  bpp_m1;
    sel_t              sel [NUM_COMP];
    logic [PIX_W-1:0]  gated;
    logic [COMP_W-1:0] comp [NUM_COMP];
    logic [RGB_W-1:0]  rgb_next;
    logic              blank;

    pcx_regs #(.BPP_W(BPP_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .bpp_m1  (bpp_m1),
        .sel     (sel)
    );

    pcx_byte_gate #(.PIX_BYTES(PIX_BYTES), .BPP_W(BPP_W)) u_gate (
        .word_i (pix_data),
        .bpp_m1 (bpp_m1),
        .word_o (gated)
    );

    assign blank = !pix_visible || pix_underrun;

    for (genvar c = 0; c < NUM_COMP; c++) begin : g_lane
        pcx_lane #(.PIX_W(PIX_W)) u_lane (
            .word       (gated),
            .sel        (sel[c]),
            .force_dflt (blank),
            .comp       (comp[c])
        );
        assign rgb_next[(NUM_COMP-1-c)*COMP_W +: COMP_W] = comp[c];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rgb_valid <= 1'b0;
            rgb_out   <= '0;
        end else begin
            rgb_valid <= pix_valid;
            if (pix_valid) begin
                rgb_out <= rgb_next;
            end
        end
    end

    // R2: output strobe is the input strobe one cycle late
    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> rgb_valid == $past(pix_valid));

    // R2: output holds across idle cycles
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(pix_valid)) |-> $stable(rgb_out));

    // R9: invisible pixels show the fallback values
    assert_blank_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(pix_valid) && !$past(pix_visible)) |->
        rgb_out == {$past(sel[0].dflt), $past(sel[1].dflt), $past(sel[2].dflt)});

    // R10: underrun pixels show the fallback values
    assert_underrun_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(pix_valid) && $past(pix_underrun)) |->
        rgb_out == {$past(sel[0].dflt), $past(sel[1].dflt), $past(sel[2].dflt)});

endmodule

// File: tb/tb_pcx_extract.sv
module tb_pcx_extract;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        pix_valid = 1'b0;
    logic [31:0] pix_data = '0;
    logic        pix_visible = 1'b1;
    logic        pix_underrun = 1'b0;
    logic        rgb_valid;
    logic [23:0] rgb_out;

    int n_checks = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [31:0] sh_fmt = '0;
    logic [31:0] sh_sel [3] = '{32'h0, 32'h0, 32'h0};

    always #10 clk = ~clk;

    pcx_extract dut (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pix_valid(pix_valid), .pix_data(pix_data),
        .pix_visible(pix_visible), .pix_underrun(pix_underrun),
        .rgb_valid(rgb_valid), .rgb_out(rgb_out)
    );

    function automatic logic [7:0] model_comp(logic [31:0] w, logic [31:0] s, bit blank);
        int l;
        logic [31:0] f;
        l = int'(s[11:8]);
        if (l > 8) l = 8;
        if (blank || l == 0) return s[23:16];
        f = (w >> s[4:0]) & ((32'd1 << l) - 1);
        f = f << (8 - l);
        return f[7:0];
    endfunction

    function automatic logic [23:0] model(logic [31:0] w, bit vis, bit und);
        int nb;
        logic [31:0] m;
        bit blank;
        nb = int'(sh_fmt[4:3]) + 1;
        m = w;
        for (int b = 0; b < 4; b++) if (b >= nb) m[b*8 +: 8] = 8'h00;
        blank = !vis || und;
        return {model_comp(m, sh_sel[0], blank), model_comp(m, sh_sel[1], blank),
                model_comp(m, sh_sel[2], blank)};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        if (a == 0) sh_fmt = d; else sh_sel[a-1] = d;
    endtask

    task automatic pix(string req, logic [31:0] w, bit vis, bit und);
        logic [23:0] exp;
        exp = model(w, vis, und);
        pix_valid = 1'b1; pix_data = w; pix_visible = vis; pix_underrun = und;
        @(negedge clk);
        pix_valid = 1'b0;
        check(req, {31'd0, rgb_valid}, 32'd1);
        check(req, {8'd0, rgb_out}, {8'd0, exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        logic [23:0] prev;
        logic [23:0] exp;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 valid", {31'd0, rgb_valid}, 32'd0);
        check("R1 rgb", {8'd0, rgb_out}, 32'd0);
        pix("R1 zero regs give zero", 32'hDEADBEEF, 1, 0);
        check("R1 explicit", {8'd0, rgb_out}, 32'd0);

        // R3 R4 R5 R12: two-byte 5/6/5 layout
        wr(2'd0, 32'h1 << 3);
        wr(2'd1, 32'h0000_050B);
        wr(2'd2, 32'h0000_0605);
        wr(2'd3, 32'h0000_0500);
        pix("R12 565", 32'h0000_F81F, 1, 0);
        check("R5 565 explicit", {8'd0, rgb_out}, 32'h00F8_00F8);
        pix("R5 565 green", 32'h0000_07E0, 1, 0);
        check("R12 green only", {8'd0, rgb_out}, 32'h0000_FC00);

        // R2: hold on idle
        prev = rgb_out;
        @(negedge clk);
        check("R2 idle valid", {31'd0, rgb_valid}, 32'd0);
        check("R2 hold", {8'd0, rgb_out}, {8'd0, prev});

        // R3: one byte per pixel gates upper bytes
        wr(2'd0, 32'h0);
        wr(2'd1, 32'h0000_0808);
        wr(2'd2, 32'h0000_0800);
        wr(2'd3, 32'h0000_0810);
        pix("R3 byte gate", 32'h55AB_CD12, 1, 0);
        check("R3 explicit", {8'd0, rgb_out}, 32'h0000_1200);
        wr(2'd0, 32'h3 << 3);
        pix("R3 four bytes", 32'h55AB_CD12, 1, 0);
        check("R3 four explicit", {8'd0, rgb_out}, 32'h00CD_12AB);

        // R7: clamp, R8: beyond top bit, R6: zero length default
        wr(2'd1, 32'h0000_0C04);
        wr(2'd2, 32'h0000_081C);
        wr(2'd3, 32'h0077_0003);
        pix("R7 clamp", 32'hF000_0AB0, 1, 0);
        check("R7 R8 R6 explicit", {8'd0, rgb_out}, 32'h00AB_0F77);

        // R9, R10: fallback values
        wr(2'd1, 32'h00FF_0800);
        wr(2'd2, 32'h0011_0800);
        pix("R9 invisible", 32'h1234_5678, 0, 0);
        check("R9 explicit", {8'd0, rgb_out}, 32'h00FF_1177);
        pix("R10 underrun", 32'h1234_5678, 1, 1);
        check("R10 explicit", {8'd0, rgb_out}, 32'h00FF_1177);

        // R11: write in same cycle as pixel uses old settings
        exp = model(32'h0000_00C3, 1, 0);
        cfg_wr_en = 1'b1; cfg_addr = 2'd1; cfg_wdata = 32'h0000_0404;
        pix_valid = 1'b1; pix_data = 32'h0000_00C3; pix_visible = 1; pix_underrun = 0;
        @(negedge clk);
        cfg_wr_en = 1'b0; pix_valid = 1'b0;
        sh_sel[0] = 32'h0000_0404;
        check("R11 old settings", {8'd0, rgb_out}, {8'd0, exp});
        pix("R11 new settings", 32'h0000_00C3, 1, 0);
        check("R11 explicit red", {24'd0, rgb_out[23:16]}, 32'h0000_00C0);

        // Random: R3 R4 R5 R6 R7 R8 R9 R10 R12
        void'($urandom(32'd12345));
        for (int k = 0; k < 60; k++) begin
            wr(2'd0, $urandom);
            wr(2'd1, $urandom);
            wr(2'd2, $urandom);
            wr(2'd3, $urandom);
            for (int p = 0; p < 6; p++) begin
                pix("R12 random", $urandom, ($urandom % 8) != 0, ($urandom % 8) == 0);
            end
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule